// File: doc/BRIEF.md
# I2C Slow-Control Target with Majority-Voted Configuration

This block is the configuration port of one readout chip that shares a two-wire I2C bus with many others. A master reaches a single chip through its 7-bit geographic address. It can also load one configuration into every chip at once through the broadcast address 0x00. The slave side contains the SCL/SDA synchronisers and bit engine, the register-pointer logic and a register file. The bit engine pulls SDA low through an open-drain style enable. In the register file every bit is held in three copies, and the effective value is the bitwise majority of the three.

An access first sets a byte-wide register pointer. A write frame is START, address with W, pointer byte, one or more data bytes, STOP. Each data byte lands at the pointer, and the pointer then advances. A read first sets the pointer with a write frame that carries no data. A second frame, with address and R, then returns bytes from the pointer. The master ACKs every byte it wants followed by another and NACKs the last one. The voted configuration drives the chip continuously on `cfg_o`. Reading it back never disturbs it, so it can be read while the chip is acquiring.

Top module: `i2c_sc_target`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_oe_o` is low and every bit of `cfg_o` is 0.
- R2: An address byte whose upper seven bits equal `chip_addr_i` (which must be 1..127) is acknowledged: SDA is pulled low during the ninth SCL clock. This holds for both R/W values (bit 0: 0 = write, 1 = read).
- R3: An address byte that matches neither the chip nor a broadcast write is not acknowledged. SDA stays released until the next START or STOP, and the registers and the pointer are unchanged.
- R4: The address byte 0x00 is a broadcast write. It is acknowledged and behaves exactly like a write frame to the chip's own address.
- R5: The address byte 0x01 (broadcast read) is never acknowledged and is handled like R3.
- R6: In a write frame the first byte after the address sets the 8-bit pointer. Each following byte is stored in register `ptr` and the pointer then increments. Every byte is acknowledged. Register r appears on `cfg_o[8r+7:8r]`.
- R7: In a read frame the slave sends the register at the pointer MSB first. The pointer is the one left by the last write frame. A master ACK advances the pointer and sends the next register. A master NACK releases SDA and ends the transfer without advancing the pointer.
- R8: With NUM_REGS = 16, a pointer of 16 or more names no register: a write there changes nothing and a read there returns 0x00. The pointer wraps from 255 to 0.
- R9: A STOP or a repeated START inside a byte discards that byte, so no register changes. A repeated START begins a new address phase and keeps the pointer.
- R10: The slave only starts pulling SDA low while SCL is low, so it never forms a START or STOP on the bus.
- R11: Each configuration bit is stored three times, and all three copies are written together. `cfg_o` and read-back show the bitwise majority, and `cfg_o` changes only when a data byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| chip_addr_i | input | 7 | Geographic address of this chip (1..127) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low; 0 = release |
| cfg_o | output | NUM_REGS*8 | Voted configuration, register r at bits 8r+7..8r |

## Verification
Two functions can land in the same cycle: the framing detector, which sees START or STOP, and the bit engine, which is in the middle of collecting a data byte. The bench provokes this by cutting a data byte after four bits with a STOP. It also sends a repeated START straight after the pointer byte's acknowledge. It judges the result at the ports. The whole configuration vector must be unchanged after the cut byte. A following read must return the register named by the interrupted frame's pointer.

// File: rtl/i2c_sc_pkg.sv
package i2c_sc_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 7;
    localparam int TMR_COPIES = 3;
    localparam int BIT_CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } sc_state_e;

    typedef enum logic [1:0] {
        PH_BITS,
        PH_ACK_SETUP,
        PH_ACK,
        PH_MACK
    } sc_phase_e;

    // Events seen on the synchronised bus lines
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    // One register write request from the bit engine
    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] vote3(
        input logic [BYTE_W-1:0] a,
        input logic [BYTE_W-1:0] b,
        input logic [BYTE_W-1:0] c
    );
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic addr_accept(
        input logic [BYTE_W-1:0] rx,
        input logic [ADDR_W-1:0] own
    );
        logic geo;
        logic bcast_wr;
        geo      = (rx[BYTE_W-1:1] == own) && (own != '0);
        bcast_wr = (rx == '0);
        return geo || bcast_wr;
    endfunction

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync
    import i2c_sc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[SYNC_STAGES-2:0], raw[l]};
            end
        end
        assign synced[l] = pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    logic scl_s, sda_s, scl_d, sda_d;
    assign scl_s = synced[1];
    assign sda_s = synced[0];
    assign scl_d = prev[1];
    assign sda_d = prev[0];

    always_comb begin
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_d;
        ev_o.scl_fall = ~scl_s & scl_d;
        ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/sc_bit_engine.sv
module sc_bit_engine
    import i2c_sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic [ADDR_W-1:0] chip_addr_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] ptr_o,
    output wr_req_t           wr_o,
    output logic              sda_oe_o
);
    sc_state_e            state;
    sc_phase_e            phase;
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-2:0]    shreg;
    logic [BYTE_W-1:0]    tx;
    logic [BYTE_W-1:0]    ptr;
    logic                 is_read;
    logic                 ack_pend;
    logic                 oe;

    logic [BYTE_W-1:0] rx_byte;
    logic              byte_ack;

    assign rx_byte = {shreg, ev_i.sda};

    always_comb begin
        if (state == ST_ADDR) begin
            byte_ack = addr_accept(rx_byte, chip_addr_i);
        end else begin
            byte_ack = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_BITS;
            cnt      <= '0;
            shreg    <= '0;
            tx       <= '0;
            ptr      <= '0;
            is_read  <= 1'b0;
            ack_pend <= 1'b0;
            oe       <= 1'b0;
            wr_o     <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (ev_i.start) begin
                state <= ST_ADDR;
                phase <= PH_BITS;
                cnt   <= '0;
                oe    <= 1'b0;
            end else if (ev_i.stop) begin
                state <= ST_IDLE;
                phase <= PH_BITS;
                cnt   <= '0;
                oe    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_REG, ST_WDATA: begin
                        case (phase)
                            PH_BITS: begin
                                if (ev_i.scl_rise) begin
                                    shreg <= {shreg[BYTE_W-3:0], ev_i.sda};
                                    cnt   <= cnt + 1'b1;
                                    if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                                        phase    <= PH_ACK_SETUP;
                                        ack_pend <= byte_ack;
                                        if (state == ST_ADDR) begin
                                            is_read <= rx_byte[0];
                                        end
                                        if (state == ST_REG) begin
                                            ptr <= rx_byte;
                                        end
                                        if (state == ST_WDATA) begin
                                            wr_o.en   <= 1'b1;
                                            wr_o.addr <= ptr;
                                            wr_o.data <= rx_byte;
                                        end
                                    end
                                end
                            end
                            PH_ACK_SETUP: begin
                                if (ev_i.scl_fall) begin
                                    if (ack_pend) begin
                                        oe    <= 1'b1;
                                        phase <= PH_ACK;
                                    end else begin
                                        state <= ST_IGNORE;
                                        phase <= PH_BITS;
                                    end
                                end
                            end
                            PH_ACK: begin
                                if (ev_i.scl_fall) begin
                                    oe    <= 1'b0;
                                    cnt   <= '0;
                                    phase <= PH_BITS;
                                    if (state == ST_ADDR) begin
                                        if (is_read) begin
                                            state <= ST_RDATA;
                                            tx    <= rd_data_i;
                                            oe    <= ~rd_data_i[BYTE_W-1];
                                        end else begin
                                            state <= ST_REG;
                                        end
                                    end else if (state == ST_REG) begin
                                        state <= ST_WDATA;
                                    end else begin
                                        ptr <= ptr + 1'b1;
                                    end
                                end
                            end
                            default: phase <= PH_BITS;
                        endcase
                    end
                    ST_RDATA: begin
                        case (phase)
                            PH_BITS: begin
                                if (ev_i.scl_rise) begin
                                    tx  <= {tx[BYTE_W-2:0], 1'b0};
                                    cnt <= cnt + 1'b1;
                                end else if (ev_i.scl_fall) begin
                                    if (cnt == BIT_CNT_W'(BYTE_W)) begin
                                        oe    <= 1'b0;
                                        phase <= PH_MACK;
                                    end else begin
                                        oe <= ~tx[BYTE_W-1];
                                    end
                                end
                            end
                            PH_MACK: begin
                                if (ev_i.scl_rise) begin
                                    ack_pend <= ~ev_i.sda;
                                    if (ev_i.sda) begin
                                        state <= ST_IGNORE;
                                        phase <= PH_BITS;
                                    end else begin
                                        ptr <= ptr + 1'b1;
                                    end
                                end else if (ev_i.scl_fall && ack_pend) begin
                                    tx    <= rd_data_i;
                                    oe    <= ~rd_data_i[BYTE_W-1];
                                    cnt   <= '0;
                                    phase <= PH_BITS;
                                end
                            end
                            default: phase <= PH_BITS;
                        endcase
                    end
                    default: begin
                        oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr_o    = ptr;
    assign sda_oe_o = oe;

endmodule

// File: rtl/sc_vote_regfile.sv
module sc_vote_regfile
    import i2c_sc_pkg::*;
#(
    parameter int                NUM_REGS  = 16,
    parameter logic [BYTE_W-1:0] RESET_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr_i,
    input  logic [BYTE_W-1:0]          rd_ptr_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [TMR_COPIES-1:0][NUM_REGS-1:0][BYTE_W-1:0] copies;
    logic [NUM_REGS-1:0][BYTE_W-1:0]                 voted;
    logic                                            wr_hit;

    assign wr_hit = wr_i.en && (wr_i.addr < BYTE_W'(NUM_REGS));

    for (genvar c = 0; c < TMR_COPIES; c++) begin : g_copy
        logic [NUM_REGS-1:0][BYTE_W-1:0] mem;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem <= {NUM_REGS{RESET_VAL}};
            end else if (wr_hit) begin
                mem[wr_i.addr[IDX_W-1:0]] <= wr_i.data;
            end
        end
        assign copies[c] = mem;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_vote
        assign voted[r] = vote3(copies[0][r], copies[1][r], copies[2][r]);
        assign cfg_o[r*BYTE_W +: BYTE_W] = voted[r];
    end

    always_comb begin
        if (rd_ptr_i < BYTE_W'(NUM_REGS)) begin
            rd_data_o = voted[rd_ptr_i[IDX_W-1:0]];
        end else begin
            rd_data_o = '0;
        end
    end

endmodule

// File: rtl/i2c_sc_target.sv
module i2c_sc_target
    import i2c_sc_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [6:0]                 chip_addr_i,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*8-1:0]      cfg_o
);
    line_ev_t          line_ev;
    wr_req_t           wr_req;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;

    sc_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (line_ev)
    );

    sc_bit_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (line_ev),
        .chip_addr_i(chip_addr_i),
        .rd_data_i  (rd_data),
        .ptr_o      (ptr),
        .wr_o       (wr_req),
        .sda_oe_o   (sda_oe_o)
    );

    sc_vote_regfile #(
        .NUM_REGS(NUM_REGS)
    ) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr_req),
        .rd_ptr_i (ptr),
        .rd_data_o(rd_data),
        .cfg_o    (cfg_o)
    );

endmodule

// File: rtl/sc_checker.sv
module sc_checker
    import i2c_sc_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic                                            clk,
    input logic                                            rst,
    input logic                                            scl_i,
    input logic                                            sda_oe,
    input sc_state_e                                       state,
    input logic                                            wr_en,
    input logic [NUM_REGS*8-1:0]                           cfg,
    input logic [TMR_COPIES-1:0][NUM_REGS-1:0][BYTE_W-1:0] copies
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && cfg == '0))
        else $error("reset state wrong");

    // R3 and R5: an ignored frame never drives the line
    assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe)
        else $error("SDA driven while not addressed");

    assert_write_only_in_data_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (state == ST_WDATA))
        else $error("write outside data phase");

    assert_pull_on_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_i))
        else $error("SDA pulled low while SCL high");

    assert_copies_agree_R11: assert property (@(posedge clk) disable iff (rst)
        (copies[0] == copies[1]) && (copies[1] == copies[2]))
        else $error("voting copies diverged");

    assert_cfg_moves_on_write_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(wr_en))
        else $error("configuration changed without a write");

endmodule

bind i2c_sc_target sc_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_oe(sda_oe_o),
    .state (u_eng.state),
    .wr_en (wr_req.en),
    .cfg   (cfg_o),
    .copies(u_rf.copies)
);

// File: tb/tb_i2c_sc_target.sv
`timescale 1ns/1ps
module tb_i2c_sc_target;

    localparam int NREG = 16;
    localparam int Q    = 6;
    localparam logic [6:0] ME = 7'h71;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 scl_m = 1'b1;
    logic                 sda_m = 1'b1;
    logic                 sda_oe_o;
    logic [NREG*8-1:0]    cfg_o;
    logic                 sda_line;

    int tests = 0;
    int fails = 0;
    int viol  = 0;
    logic oe_prev = 1'b0;

    logic [7:0] exp_cfg [NREG];
    logic [7:0] exp_ptr;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    i2c_sc_target #(.NUM_REGS(NREG)) dut (
        .clk        (clk),
        .rst        (rst),
        .chip_addr_i(ME),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe_o),
        .cfg_o      (cfg_o)
    );

    // R10 monitor: the slave's drive may only move while SCL is low
    always @(negedge clk) begin
        if (!rst && (sda_oe_o != oe_prev) && scl_m) viol++;
        oe_prev = sda_oe_o;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] p);
        return (p < NREG) ? exp_cfg[p] : 8'h00;
    endfunction

    function automatic logic exp_addr_ack(input logic [7:0] ab);
        return (ab[7:1] == ME) || (ab == 8'h00);
    endfunction

    task automatic cmp_cfg(input string req);
        logic ok = 1'b1;
        int bad = 0;
        for (int r = 0; r < NREG; r++) begin
            if (cfg_o[r*8 +: 8] !== exp_cfg[r]) begin
                ok = 1'b0;
                bad = r;
            end
        end
        chk(ok, req, 32'(cfg_o[bad*8 +: 8]), 32'(exp_cfg[bad]));
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~mack);
    endtask

    // Write frame: pointer byte then n data bytes (n <= 3)
    task automatic wr_frame(input logic [7:0] ab, input logic [7:0] rb, input int n,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input string req);
        logic ack;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        send_byte(ab, ack);
        chk(ack == exp_addr_ack(ab), {req, " address ack"}, 32'(ack), 32'(exp_addr_ack(ab)));
        if (!ack) begin
            put_bit(1'b0);
            bus_stop();
            cmp_cfg({req, " ignored frame leaves cfg (R3)"});
            return;
        end
        send_byte(rb, ack);
        chk(ack, {req, " pointer ack (R6)"}, 32'(ack), 1);
        exp_ptr = rb;
        for (int i = 0; i < n; i++) begin
            send_byte(dv[i], ack);
            chk(ack, {req, " data ack (R6)"}, 32'(ack), 1);
            if (exp_ptr < NREG) exp_cfg[exp_ptr] = dv[i];
            exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
        cmp_cfg({req, " cfg after write (R6/R11)"});
    endtask

    task automatic rd_frame(input logic [7:0] ab, input int n, input string req);
        logic ack;
        logic [7:0] d;
        logic expa;
        expa = (ab[7:1] == ME);
        bus_start();
        send_byte(ab, ack);
        chk(ack == expa, {req, " read address ack"}, 32'(ack), 32'(expa));
        if (!ack) begin
            bus_stop();
            return;
        end
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == model_rd(exp_ptr), {req, " read data (R7/R11)"}, 32'(d),
                32'(model_rd(exp_ptr)));
            if (i < n - 1) exp_ptr = exp_ptr + 8'd1;
        end
        chk(sda_oe_o == 1'b0, {req, " SDA released after NACK (R7)"}, 32'(sda_oe_o), 0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        void'($urandom(32'h5C0F_1234));
        for (int r = 0; r < NREG; r++) exp_cfg[r] = 8'h00;
        exp_ptr = 8'h00;
        tick(6);
        chk(sda_oe_o == 1'b0, "R1 sda_oe during reset", 32'(sda_oe_o), 0);
        rst = 1'b0;
        tick(2);
        chk(sda_oe_o == 1'b0, "R1 sda_oe after reset", 32'(sda_oe_o), 0);
        cmp_cfg("R1 cfg after reset");

        // R2 / R6: own address, single byte
        wr_frame({ME, 1'b0}, 8'd2, 1, 8'hA5, 8'h00, 8'h00, "R2 own write");
        // R4: broadcast write, burst with increment
        wr_frame(8'h00, 8'd5, 3, 8'h11, 8'h22, 8'h33, "R4 broadcast burst");
        // R7: pointer-only frame then multi-byte read
        wr_frame({ME, 1'b0}, 8'd5, 0, 8'h00, 8'h00, 8'h00, "R7 set pointer");
        rd_frame({ME, 1'b1}, 3, "R7 burst read");
        // R3: foreign address ignored, pointer untouched
        wr_frame({7'h12, 1'b0}, 8'd9, 2, 8'hEE, 8'hEE, 8'h00, "R3 foreign write");
        wr_frame({ME, 1'b0}, 8'd2, 0, 8'h00, 8'h00, 8'h00, "R3 set pointer");
        rd_frame({7'h12, 1'b1}, 1, "R3 foreign read");
        rd_frame({ME, 1'b1}, 1, "R3 pointer kept");
        // R5: broadcast read never acknowledged
        rd_frame(8'h01, 1, "R5 broadcast read");
        // R8: out-of-range and wrap
        wr_frame({ME, 1'b0}, 8'd20, 1, 8'h5A, 8'h00, 8'h00, "R8 write out of range");
        wr_frame({ME, 1'b0}, 8'd15, 0, 8'h00, 8'h00, 8'h00, "R8 pointer 15");
        rd_frame({ME, 1'b1}, 2, "R8 read across end");
        wr_frame({ME, 1'b0}, 8'hFF, 2, 8'h77, 8'h3C, 8'h00, "R8 wrap to 0");

        // R9: STOP inside a data byte
        bus_start();
        send_byte({ME, 1'b0}, ack);
        send_byte(8'd3, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        cmp_cfg("R9 cut byte leaves cfg");
        // R9: repeated START after pointer byte, then read
        bus_start();
        send_byte({ME, 1'b0}, ack);
        send_byte(8'd6, ack);
        exp_ptr = 8'd6;
        bus_start();
        send_byte({ME, 1'b1}, ack);
        chk(ack, "R9 address after repeated start", 32'(ack), 1);
        recv_byte(1'b0, d);
        chk(d == model_rd(8'd6), "R9 read after repeated start", 32'(d), 32'(model_rd(8'd6)));
        bus_stop();
        cmp_cfg("R9 cfg after repeated start");

        // Constrained random traffic
        for (int it = 0; it < 40; it++) begin
            int op;
            logic [7:0] rb;
            logic [6:0] other;
            op = $urandom % 6;
            rb = 8'($urandom % 20);
            other = 7'(1 + ($urandom % 127));
            if (other == ME) other = ME ^ 7'h01;
            case (op)
                0, 1: wr_frame({ME, 1'b0}, rb, 1 + ($urandom % 3), 8'($urandom),
                               8'($urandom), 8'($urandom), "R6 random write");
                2: wr_frame(8'h00, rb, 1 + ($urandom % 3), 8'($urandom),
                            8'($urandom), 8'($urandom), "R4 random broadcast");
                3: begin
                    wr_frame({ME, 1'b0}, rb, 0, 8'h00, 8'h00, 8'h00, "R7 random pointer");
                    rd_frame({ME, 1'b1}, 1 + ($urandom % 3), "R7 random read");
                end
                4: wr_frame({other, 1'b0}, rb, 1, 8'($urandom), 8'h00, 8'h00,
                            "R3 random foreign");
                default: rd_frame(8'h01, 1, "R5 random broadcast read");
            endcase
        end

        chk(viol == 0, "R10 SDA moved while SCL high", 32'(viol), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule